// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Vector Unit

This unit serves the processor's interrupt-acknowledge cycle for two chained 8-input interrupt controllers. The secondary controller reports into input 2 of the primary. The unit keeps the request-latch and in-service state for both controllers. It turns the raw request lines into latched requests, using an edge or a level rule chosen per input. On an acknowledge strobe it consumes the winning input of each controller and returns an 8-bit vector together with a 4-bit global interrupt number.

The choice of winner is made outside the unit. External priority logic reads the exported request, in-service and rotation-base state and presents a valid flag and an index for each controller. Vector bases, auto-EOI and rotate-on-auto-EOI settings also arrive as plain inputs from the programming logic. When the primary has no winner, or the cascade input wins while the secondary has none, the unit returns a spurious vector for input 7 of the controller concerned.

Top module: `casc_ack_vector`

## Requirements
- R1: After reset, `irr_o`, `isr_o`, `m_rot_o`, `s_rot_o`, `ack_done_o` and `int_o` are all zero.
- R2: Bit k of `irr_o` and `isr_o` belongs to global input k (0..7 primary, 8..15 secondary). With `level_i[k]`=0 the request bit sets one cycle after a rising edge on `irq_i[k]` and stays set when the line drops. With `level_i[k]`=1 the request bit follows the line, one cycle later.
- R3: `irq_i[2]` and `level_i[2]` are ignored. Whenever `s_win_vld_i` is high, `irr_o[2]` is set on the next cycle and stays set until acknowledged.
- R4: An acknowledge sampled with `ack_i`=1 makes `ack_done_o` high for exactly the following cycle, with `vec_o` and `irq_num_o` valid in that cycle. Without auto-EOI, the winner's in-service bit is then set.
- R5: An acknowledge clears the winner's request bit only when that input is edge-triggered. A level-triggered request bit stays set while its line is high.
- R6: With auto-EOI enabled for a controller (`aeoi_i` bit 0 primary, bit 1 secondary), the acknowledged in-service bit ends up clear. If rotate-on-auto-EOI is also set, that controller's rotation base becomes (winner+1) mod 8. Otherwise the base is unchanged.
- R7: When the primary winner is input 2 and the secondary has a winner s, both are acknowledged. `vec_o` = (`s_base_i` AND 0xF8) + s and `irq_num_o` = s+8.
- R8: When the primary winner is input 2 and the secondary has none, primary input 2 is acknowledged, the secondary state is untouched, `vec_o` = (`s_base_i` AND 0xF8)+7 and `irq_num_o` = 15.
- R9: When the primary has no winner, no state changes, `vec_o` = (`m_base_i` AND 0xF8)+7 and `irq_num_o` = 7.
- R10: For a primary winner m other than 2, `vec_o` = (`m_base_i` AND 0xF8) + m and `irq_num_o` = m. The low three bits of either base never reach the vector.
- R11: `int_o` repeats `m_win_vld_i` one cycle later. It is forced low in the cycle where `ack_done_o` is high, so the request is re-evaluated against the updated state afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Raw request lines, bit k is global input k |
| level_i | input | 16 | Trigger mode per input, 1 = level, 0 = edge |
| m_base_i | input | 8 | Primary vector base |
| s_base_i | input | 8 | Secondary vector base |
| aeoi_i | input | 2 | Auto-EOI enable, bit 0 primary, bit 1 secondary |
| rot_aeoi_i | input | 2 | Rotate-on-auto-EOI, bit 0 primary, bit 1 secondary |
| m_win_vld_i | input | 1 | Primary has a winning input |
| m_win_i | input | 3 | Primary winning input index |
| s_win_vld_i | input | 1 | Secondary has a winning input |
| s_win_i | input | 3 | Secondary winning input index |
| ack_i | input | 1 | Interrupt-acknowledge strobe |
| ack_done_o | output | 1 | One-cycle acknowledge completion pulse |
| vec_o | output | 8 | Returned vector |
| irq_num_o | output | 4 | Global interrupt number |
| int_o | output | 1 | Interrupt request to the processor |
| irr_o | output | 16 | Latched request bits |
| isr_o | output | 16 | In-service bits |
| m_rot_o | output | 3 | Primary rotation base |
| s_rot_o | output | 3 | Secondary rotation base |

## Verification
A wrong edge-detect history or trigger decision shows up in `irr_o` one cycle after the line moves. A wrong in-service or rotation update shows up in `isr_o` or the rotation base in the `ack_done_o` cycle. Mis-steering at the cascade point is the subtle failure: it gives a vector built from the wrong base, or a number off by 8, in that same cycle. It can also leave a stray secondary in-service bit that the external priority logic would feel only on a later acknowledge, so the in-service vector is compared in full after every acknowledge.

// File: rtl/ackvec_pkg.sv
package ackvec_pkg;
    parameter int unsigned CTRL_IN  = 8;
    parameter int unsigned VEC_W    = 8;
    parameter int unsigned CASC_IN  = 2;
    localparam int unsigned IDX_W   = $clog2(CTRL_IN);
    localparam int unsigned TOT_IN  = 2 * CTRL_IN;
    localparam int unsigned NUM_W   = IDX_W + 1;

    typedef logic [CTRL_IN-1:0] bits_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef struct packed {
        bits_t irr;
        bits_t last;
        bits_t isr;
        idx_t  rot;
    } bank_st_t;

    typedef struct packed {
        logic             done;
        logic [VEC_W-1:0] vec;
        logic [NUM_W-1:0] num;
        logic             intr;
    } ack_out_t;
endpackage

// File: rtl/ackvec_bank.sv
module ackvec_bank
    import ackvec_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  bits_t line_i,
    input  bits_t level_i,
    input  bits_t set_i,
    input  logic  ack_i,
    input  idx_t  ack_idx_i,
    input  logic  aeoi_i,
    input  logic  rot_aeoi_i,
    output bits_t irr_o,
    output bits_t isr_o,
    output idx_t  rot_o
);
    bank_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.last = line_i;
        for (int i = 0; i < CTRL_IN; i++) begin
            if (level_i[i]) begin
                st_d.irr[i] = line_i[i];
            end else if ((line_i[i] && !st_q.last[i]) || set_i[i]) begin
                st_d.irr[i] = 1'b1;
            end
        end
        if (ack_i) begin
            // in-service is set, then dropped at once under auto-EOI
            if (aeoi_i) begin
                st_d.isr[ack_idx_i] = 1'b0;
                if (rot_aeoi_i) begin
                    st_d.rot = ack_idx_i + idx_t'(1);
                end
            end else begin
                st_d.isr[ack_idx_i] = 1'b1;
            end
            if (!level_i[ack_idx_i]) begin
                st_d.irr[ack_idx_i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irr_o = st_q.irr;
    assign isr_o = st_q.isr;
    assign rot_o = st_q.rot;
endmodule

// File: rtl/ackvec_sel.sv
module ackvec_sel
    import ackvec_pkg::*;
(
    input  logic             m_vld_i,
    input  idx_t             m_win_i,
    input  logic             s_vld_i,
    input  idx_t             s_win_i,
    input  logic [VEC_W-1:0] m_base_i,
    input  logic [VEC_W-1:0] s_base_i,
    output logic             ack_m_o,
    output logic             ack_s_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [NUM_W-1:0] num_o
);
    localparam idx_t SPUR = idx_t'(CTRL_IN - 1);
    localparam idx_t CASC = idx_t'(CASC_IN);

    always_comb begin
        ack_m_o = 1'b0;
        ack_s_o = 1'b0;
        vec_o   = {m_base_i[VEC_W-1:IDX_W], SPUR};
        num_o   = {1'b0, SPUR};
        if (m_vld_i) begin
            ack_m_o = 1'b1;
            if (m_win_i == CASC) begin
                if (s_vld_i) begin
                    ack_s_o = 1'b1;
                    vec_o   = {s_base_i[VEC_W-1:IDX_W], s_win_i};
                    num_o   = {1'b1, s_win_i};
                end else begin
                    vec_o   = {s_base_i[VEC_W-1:IDX_W], SPUR};
                    num_o   = {1'b1, SPUR};
                end
            end else begin
                vec_o = {m_base_i[VEC_W-1:IDX_W], m_win_i};
                num_o = {1'b0, m_win_i};
            end
        end
    end
endmodule

// File: rtl/casc_ack_vector.sv
module casc_ack_vector
    import ackvec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       irq_i,
    input  logic [15:0]       level_i,
    input  logic [7:0]        m_base_i,
    input  logic [7:0]        s_base_i,
    input  logic [1:0]        aeoi_i,
    input  logic [1:0]        rot_aeoi_i,
    input  logic              m_win_vld_i,
    input  logic [2:0]        m_win_i,
    input  logic              s_win_vld_i,
    input  logic [2:0]        s_win_i,
    input  logic              ack_i,
    output logic              ack_done_o,
    output logic [7:0]        vec_o,
    output logic [3:0]        irq_num_o,
    output logic              int_o,
    output logic [15:0]       irr_o,
    output logic [15:0]       isr_o,
    output logic [2:0]        m_rot_o,
    output logic [2:0]        s_rot_o
);
    localparam bits_t CASC_BIT = bits_t'(1) << CASC_IN;

    logic             sel_ack_m, sel_ack_s;
    logic [VEC_W-1:0] sel_vec;
    logic [NUM_W-1:0] sel_num;

    bits_t line_a  [2];
    bits_t level_a [2];
    bits_t set_a   [2];
    logic  ack_a   [2];
    idx_t  idx_a   [2];
    bits_t irr_a   [2];
    bits_t isr_a   [2];
    idx_t  rot_a   [2];

    ackvec_sel u_sel (
        .m_vld_i  (m_win_vld_i),
        .m_win_i  (m_win_i),
        .s_vld_i  (s_win_vld_i),
        .s_win_i  (s_win_i),
        .m_base_i (m_base_i),
        .s_base_i (s_base_i),
        .ack_m_o  (sel_ack_m),
        .ack_s_o  (sel_ack_s),
        .vec_o    (sel_vec),
        .num_o    (sel_num)
    );

    // primary: cascade input is an edge strobe driven by the secondary winner
    assign line_a[0]  = irq_i[CTRL_IN-1:0] & ~CASC_BIT;
    assign level_a[0] = level_i[CTRL_IN-1:0] & ~CASC_BIT;
    assign set_a[0]   = s_win_vld_i ? CASC_BIT : '0;
    assign ack_a[0]   = ack_i && sel_ack_m;
    assign idx_a[0]   = m_win_i;

    assign line_a[1]  = irq_i[TOT_IN-1:CTRL_IN];
    assign level_a[1] = level_i[TOT_IN-1:CTRL_IN];
    assign set_a[1]   = '0;
    assign ack_a[1]   = ack_i && sel_ack_s;
    assign idx_a[1]   = s_win_i;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        ackvec_bank u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_i     (line_a[g]),
            .level_i    (level_a[g]),
            .set_i      (set_a[g]),
            .ack_i      (ack_a[g]),
            .ack_idx_i  (idx_a[g]),
            .aeoi_i     (aeoi_i[g]),
            .rot_aeoi_i (rot_aeoi_i[g]),
            .irr_o      (irr_a[g]),
            .isr_o      (isr_a[g]),
            .rot_o      (rot_a[g])
        );
    end

    ack_out_t out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.done = ack_i;
        out_d.intr = m_win_vld_i && !ack_i;
        if (ack_i) begin
            out_d.vec = sel_vec;
            out_d.num = sel_num;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ack_done_o = out_q.done;
    assign vec_o      = out_q.vec;
    assign irq_num_o  = out_q.num;
    assign int_o      = out_q.intr;
    assign irr_o      = {irr_a[1], irr_a[0]};
    assign isr_o      = {isr_a[1], isr_a[0]};
    assign m_rot_o    = rot_a[0];
    assign s_rot_o    = rot_a[1];
endmodule

// File: rtl/casc_ack_vector_chk.sv
module casc_ack_vector_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  aeoi_i,
    input logic [1:0]  rot_aeoi_i,
    input logic        m_win_vld_i,
    input logic [2:0]  m_win_i,
    input logic        s_win_vld_i,
    input logic        ack_i,
    input logic        ack_done_o,
    input logic [3:0]  irq_num_o,
    input logic        int_o,
    input logic [15:0] irr_o,
    input logic [15:0] isr_o,
    input logic [2:0]  m_rot_o
);
    logic [2:0] idx_q;
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= m_win_i;
    end

    // R4
    done_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> ack_done_o);
    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !ack_done_o);
    // R4
    isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && m_win_vld_i && !aeoi_i[0]) |=> isr_o[idx_q]);
    // R6
    rot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && m_win_vld_i && aeoi_i[0] && rot_aeoi_i[0]) |=> (m_rot_o == idx_q + 3'd1));
    // R9
    spur_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !m_win_vld_i) |=> (irq_num_o == 4'd7));
    // R9
    spur_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !m_win_vld_i) |=> $stable(isr_o));
    // R3
    casc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_win_vld_i && !(ack_i && m_win_vld_i && m_win_i == 3'd2)) |=> irr_o[2]);
    // R11
    int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done_o |-> !int_o);
endmodule

bind casc_ack_vector casc_ack_vector_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .aeoi_i      (aeoi_i),
    .rot_aeoi_i  (rot_aeoi_i),
    .m_win_vld_i (m_win_vld_i),
    .m_win_i     (m_win_i),
    .s_win_vld_i (s_win_vld_i),
    .ack_i       (ack_i),
    .ack_done_o  (ack_done_o),
    .irq_num_o   (irq_num_o),
    .int_o       (int_o),
    .irr_o       (irr_o),
    .isr_o       (isr_o),
    .m_rot_o     (m_rot_o)
);

// File: tb/casc_ack_vector_test.sv
module casc_ack_vector_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_i, level_i;
    logic [7:0]  m_base_i, s_base_i;
    logic [1:0]  aeoi_i, rot_aeoi_i;
    logic        m_win_vld_i, s_win_vld_i, ack_i;
    logic [2:0]  m_win_i, s_win_i;
    logic        ack_done_o, int_o;
    logic [7:0]  vec_o;
    logic [3:0]  irq_num_o;
    logic [15:0] irr_o, isr_o;
    logic [2:0]  m_rot_o, s_rot_o;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    casc_ack_vector uut (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; irq_i = '0; level_i = '0; aeoi_i = '0; rot_aeoi_i = '0;
        m_win_vld_i = 0; m_win_i = '0; s_win_vld_i = 0; s_win_i = '0; ack_i = 0;
        m_base_i = 8'h23; s_base_i = 8'h75;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // acknowledge with given winners; returns at negedge of the done cycle
    task automatic do_ack(logic mv, logic [2:0] mw, logic sv, logic [2:0] sw);
        m_win_vld_i = mv; m_win_i = mw; s_win_vld_i = sv; s_win_i = sw; ack_i = 1;
        @(negedge clk);
        ack_i = 0; m_win_vld_i = 0; s_win_vld_i = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 irr", irr_o, 0);
        check("R1 isr", isr_o, 0);
        check("R1 rot", {m_rot_o, s_rot_o}, 0);
        check("R1 done/int", {ack_done_o, int_o}, 0);
    endtask

    task automatic t_trigger();
        do_reset();
        level_i = 16'h0204;          // bit 9 level; bit 2 level ignored
        irq_i = 16'h0224;            // bits 5, 9 and 2 rise
        @(negedge clk);
        check("R2 edge set", irr_o[5], 1);
        check("R2 level set", irr_o[9], 1);
        check("R3 raw line 2 ignored", irr_o[2], 0);
        irq_i = '0;
        @(negedge clk);
        check("R2 edge held", irr_o[5], 1);
        check("R2 level follows", irr_o[9], 0);
    endtask

    task automatic t_cascade();
        do_reset();
        s_win_vld_i = 1;
        @(negedge clk);
        s_win_vld_i = 0;
        check("R3 cascade latch", irr_o[2], 1);
        @(negedge clk);
        check("R3 cascade held", irr_o[2], 1);
    endtask

    task automatic t_ack_master();
        do_reset();
        level_i = 16'h0010;
        irq_i = 16'h0030;            // bit 5 edge, bit 4 level
        @(negedge clk);
        do_ack(1, 3'd5, 0, 3'd0);
        check("R4 done", ack_done_o, 1);
        check("R10 vec", vec_o, 8'h25);
        check("R10 num", irq_num_o, 5);
        check("R4 isr", isr_o, 16'h0020);
        check("R5 edge irr cleared", irr_o[5], 0);
        @(negedge clk);
        check("R4 done single", ack_done_o, 0);
        do_ack(1, 3'd4, 0, 3'd0);
        check("R5 level irr kept", irr_o[4], 1);
        check("R4 isr level", isr_o, 16'h0030);
        check("R10 vec level", vec_o, 8'h24);
    endtask

    task automatic t_aeoi();
        do_reset();
        aeoi_i = 2'b01; rot_aeoi_i = 2'b01;
        do_ack(1, 3'd6, 0, 3'd0);
        check("R6 aeoi isr", isr_o, 0);
        check("R6 rot", m_rot_o, 7);
        do_ack(1, 3'd7, 0, 3'd0);
        check("R6 rot wrap", m_rot_o, 0);
        rot_aeoi_i = 2'b00;
        do_ack(1, 3'd3, 0, 3'd0);
        check("R6 rot hold", m_rot_o, 0);
        check("R6 aeoi isr hold", isr_o, 0);
        aeoi_i = 2'b10; rot_aeoi_i = 2'b10;
        do_ack(1, 3'd2, 1, 3'd4);
        check("R6 slave rot", s_rot_o, 5);
        check("R6 slave aeoi isr", isr_o, 16'h0004);
    endtask

    task automatic t_slave();
        do_reset();
        do_ack(1, 3'd2, 1, 3'd3);
        check("R7 vec", vec_o, 8'h73);
        check("R7 num", irq_num_o, 11);
        check("R7 isr", isr_o, 16'h0804);
        do_reset();
        do_ack(1, 3'd2, 0, 3'd3);
        check("R8 vec", vec_o, 8'h77);
        check("R8 num", irq_num_o, 15);
        check("R8 isr", isr_o, 16'h0004);
    endtask

    task automatic t_spurious();
        do_reset();
        do_ack(0, 3'd5, 1, 3'd1);
        check("R9 vec", vec_o, 8'h27);
        check("R9 num", irq_num_o, 7);
        check("R9 isr", isr_o, 0);
        check("R9 done", ack_done_o, 1);
    endtask

    task automatic t_int();
        do_reset();
        m_win_vld_i = 1; m_win_i = 3'd1;
        @(negedge clk);
        check("R11 int follows", int_o, 1);
        ack_i = 1;
        @(negedge clk);
        ack_i = 0;
        check("R11 int low at done", int_o, 0);
        @(negedge clk);
        check("R11 int back", int_o, 1);
        m_win_vld_i = 0;
        @(negedge clk);
        check("R11 int drops", int_o, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 0;
        t_reset();
        t_trigger();
        t_cascade();
        t_ack_master();
        t_aeoi();
        t_slave();
        t_spurious();
        t_int();
        finish_run();
    end
endmodule